// File: doc/BRIEF.md
# Multi-Requester Associative Lock Table

This unit keeps a small, fully associative table of locks. A lock is named by an identifier from a namespace of its own, which is kept apart from memory addresses. Ordinary loads and stores never reach the unit. Several requester ports share it. Each port can ask to acquire a lock, giving an identifier and a value, or to release a lock, giving only the identifier. Every accepted request returns a two-bit result code to the port that made it.

Requests from different ports are serialised by an arbiter that grants one request per cycle. The lookup, the decision and the table update for the granted request all happen in that cycle, so each update is atomic with respect to the other ports. A requester holds its request until it sees its grant. The result comes back one cycle after the grant.

A permitted identifier window is captured from two configuration inputs while reset is asserted. A request whose identifier falls outside that window does not touch the table. Instead it raises a one-cycle trap that names the offending port.

Top module: `lock_table_unit`

## Requirements
- R1: While `rst` is high, no request is granted and no response or trap is produced; after reset the table holds no entries.
- R2: At most one port is granted per cycle, and only a port with `req_valid` high. `req_gnt` is combinational in the same cycle. Grants rotate round-robin, starting the search at the port after the last one granted (port 0 after reset).
- R3: Exactly one cycle after a grant of an in-range request, `rsp_valid` pulses for one cycle on the bit of the granted port only. Without a grant, `rsp_valid` stays low.
- R4: An acquire (`req_op` = 0) of an identifier that has no entry, while a free entry exists, creates an entry holding the identifier, the port number and the value. It returns code 0 (success) with `rsp_data` = 0.
- R5: An acquire of an identifier whose entry belongs to another port returns code 1 (held elsewhere) with `rsp_data` = 0, and leaves the entry unchanged.
- R6: An acquire by the port that already owns the identifier returns code 0 with `rsp_data` equal to the stored value. It adds no second entry and leaves the stored value unchanged.
- R7: An acquire of an identifier that has no entry, while all entries are in use, returns code 2 (table full) and changes nothing.
- R8: A release (`req_op` = 1) by the recorded owner returns code 0 with `rsp_data` equal to the stored value and frees the entry for reuse.
- R9: A release of an identifier that has no entry, or that belongs to another port, returns code 3 (not owner) with `rsp_data` = 0 and leaves the table unchanged.
- R10: A granted request whose identifier lies outside the inclusive window [`cfg_id_lo`, `cfg_id_hi`] produces, one cycle later, a one-cycle `trap_valid` pulse with `trap_port` set to the granted port. It produces no `rsp_valid` and leaves the table unchanged. The window is taken only while `rst` is high, and later changes to the configuration inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; also loads the identifier window |
| cfg_id_lo | input | ID_W | Lowest permitted identifier, sampled during reset |
| cfg_id_hi | input | ID_W | Highest permitted identifier, sampled during reset |
| req_valid | input | NUM_PORTS | Per-port request pending, held until granted |
| req_op | input | NUM_PORTS | Per-port operation: 0 acquire, 1 release |
| req_id | input | NUM_PORTS*ID_W | Per-port lock identifier, port p at bits [p*ID_W +: ID_W] |
| req_val | input | NUM_PORTS*VAL_W | Per-port value stored on acquire, port p at bits [p*VAL_W +: VAL_W] |
| req_gnt | output | NUM_PORTS | One-hot grant, same cycle as the request |
| rsp_valid | output | NUM_PORTS | One-hot response strobe for the port granted one cycle earlier |
| rsp_code | output | 2 | Result: 0 success, 1 held elsewhere, 2 full, 3 not owner |
| rsp_data | output | VAL_W | Stored value returned on owner hits, otherwise 0 |
| trap_valid | output | 1 | One-cycle pulse for an out-of-window identifier |
| trap_port | output | $clog2(NUM_PORTS) | Port that caused the trap |

## Verification
The hardest case to reach is a table that is full and contended at the same time: several ports want different identifiers, some of them new, while other ports re-acquire or release entries they already own, so that success, full and ownership outcomes depend on the order in which the arbiter serves them. The bench builds this in two ways. First it fills every entry from all ports at once and then mixes re-acquires, releases and fresh acquires. Then it runs a long pseudo-random stream from all four ports over a set of identifiers slightly larger than the table, which also straddles the lower window edge. A behavioural model with its own round-robin pointer predicts each grant and each result cycle by cycle.

// File: rtl/lock_pkg.sv
package lock_pkg;

   typedef enum logic [1:0] {
      RES_OK        = 2'd0,
      RES_BUSY      = 2'd1,
      RES_FULL      = 2'd2,
      RES_NOT_OWNER = 2'd3
   } lock_res_e;

   localparam logic OP_ACQUIRE = 1'b0;
   localparam logic OP_RELEASE = 1'b1;

endpackage

// File: rtl/lock_rr_arbiter.sv
module lock_rr_arbiter #(
   parameter int N           = 4,
   parameter bit ROUND_ROBIN = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [N-1:0]           req,
   output logic [N-1:0]           gnt,
   output logic [$clog2(N)-1:0]   gnt_idx,
   output logic                   gnt_any
);

   localparam int IW = $clog2(N);

   initial begin : param_chk
      assert (N >= 2) else $error("lock_rr_arbiter: N must be at least 2");
   end

   generate
      if (ROUND_ROBIN) begin : g_rr
         logic [IW-1:0] ptr_q;
         logic [IW-1:0] cand;
         logic [IW-1:0] idx;
         logic          any;

         always_comb begin
            any  = 1'b0;
            idx  = '0;
            cand = '0;
            for (int k = 0; k < N; k++) begin
               cand = IW'((int'(ptr_q) + k) % N);
               if (!any && req[cand]) begin
                  any = 1'b1;
                  idx = cand;
               end
            end
         end

         always_ff @(posedge clk) begin
            if (rst) begin
               ptr_q <= '0;
            end else if (any) begin
               ptr_q <= (int'(idx) == N - 1) ? '0 : idx + 1'b1;
            end
         end

         assign gnt_idx = idx;
         assign gnt_any = any;
      end else begin : g_fixed
         logic [IW-1:0] idx;

         always_comb begin
            idx = '0;
            for (int k = N - 1; k >= 0; k--) begin
               if (req[k]) idx = IW'(k);
            end
         end

         assign gnt_idx = idx;
         assign gnt_any = |req;
      end
   endgenerate

   assign gnt = gnt_any ? (N'(1) << gnt_idx) : '0;

endmodule

// File: rtl/lock_entry_match.sv
module lock_entry_match #(
   parameter int ENTRIES = 8,
   parameter int KEY_W   = 16
) (
   input  logic [ENTRIES-1:0]          ent_valid,
   input  logic [ENTRIES*KEY_W-1:0]    ent_key,
   input  logic [KEY_W-1:0]            key,
   output logic                        hit_any,
   output logic [$clog2(ENTRIES)-1:0]  hit_idx,
   output logic                        free_any,
   output logic [$clog2(ENTRIES)-1:0]  free_idx
);

   localparam int EW = $clog2(ENTRIES);

   logic [ENTRIES-1:0] hit;

   generate
      for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
         assign hit[e] = ent_valid[e] && (ent_key[e*KEY_W +: KEY_W] == key);
      end
   endgenerate

   always_comb begin
      hit_idx = '0;
      for (int e = 0; e < ENTRIES; e++) begin
         if (hit[e]) hit_idx = EW'(e);
      end
   end

   always_comb begin
      free_idx = '0;
      for (int e = ENTRIES - 1; e >= 0; e--) begin
         if (!ent_valid[e]) free_idx = EW'(e);
      end
   end

   assign hit_any  = |hit;
   assign free_any = ~&ent_valid;

endmodule

// File: rtl/lock_entry_store.sv
module lock_entry_store #(
   parameter int ENTRIES = 8,
   parameter int KEY_W   = 16,
   parameter int OWN_W   = 2,
   parameter int VAL_W   = 32
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         alloc_en,
   input  logic [$clog2(ENTRIES)-1:0]   alloc_idx,
   input  logic [KEY_W-1:0]             alloc_key,
   input  logic [OWN_W-1:0]             alloc_own,
   input  logic [VAL_W-1:0]             alloc_val,
   input  logic                         clear_en,
   input  logic [$clog2(ENTRIES)-1:0]   clear_idx,
   output logic [ENTRIES-1:0]           ent_valid,
   output logic [ENTRIES*KEY_W-1:0]     ent_key,
   output logic [ENTRIES*OWN_W-1:0]     ent_own,
   output logic [ENTRIES*VAL_W-1:0]     ent_val
);

   generate
      for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
         logic             v_q;
         logic [KEY_W-1:0] k_q;
         logic [OWN_W-1:0] o_q;
         logic [VAL_W-1:0] d_q;

         always_ff @(posedge clk) begin
            if (rst) begin
               v_q <= 1'b0;
               k_q <= '0;
               o_q <= '0;
               d_q <= '0;
            end else if (alloc_en && (int'(alloc_idx) == e)) begin
               v_q <= 1'b1;
               k_q <= alloc_key;
               o_q <= alloc_own;
               d_q <= alloc_val;
            end else if (clear_en && (int'(clear_idx) == e)) begin
               v_q <= 1'b0;
            end
         end

         assign ent_valid[e]                = v_q;
         assign ent_key[e*KEY_W +: KEY_W]   = k_q;
         assign ent_own[e*OWN_W +: OWN_W]   = o_q;
         assign ent_val[e*VAL_W +: VAL_W]   = d_q;
      end
   endgenerate

endmodule

// File: rtl/lock_table_unit.sv
module lock_table_unit
   import lock_pkg::*;
#(
   parameter int NUM_PORTS       = 4,
   parameter int NUM_ENTRIES     = 8,
   parameter int ID_W            = 16,
   parameter int VAL_W           = 32,
   parameter bit ARB_ROUND_ROBIN = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic [ID_W-1:0]               cfg_id_lo,
   input  logic [ID_W-1:0]               cfg_id_hi,
   input  logic [NUM_PORTS-1:0]          req_valid,
   input  logic [NUM_PORTS-1:0]          req_op,
   input  logic [NUM_PORTS*ID_W-1:0]     req_id,
   input  logic [NUM_PORTS*VAL_W-1:0]    req_val,
   output logic [NUM_PORTS-1:0]          req_gnt,
   output logic [NUM_PORTS-1:0]          rsp_valid,
   output logic [1:0]                    rsp_code,
   output logic [VAL_W-1:0]              rsp_data,
   output logic                          trap_valid,
   output logic [$clog2(NUM_PORTS)-1:0]  trap_port
);

   localparam int PW = $clog2(NUM_PORTS);
   localparam int EW = $clog2(NUM_ENTRIES);

   initial begin : param_chk
      assert (NUM_PORTS >= 2)   else $error("lock_table_unit: NUM_PORTS must be at least 2");
      assert (NUM_ENTRIES >= 2) else $error("lock_table_unit: NUM_ENTRIES must be at least 2");
      assert (ID_W >= 1)        else $error("lock_table_unit: ID_W must be positive");
      assert (VAL_W >= 1)       else $error("lock_table_unit: VAL_W must be positive");
   end

   // identifier window, captured while reset is held
   logic [ID_W-1:0] lo_q, hi_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         lo_q <= cfg_id_lo;
         hi_q <= cfg_id_hi;
      end
   end

   // arbitration
   logic [NUM_PORTS-1:0] arb_req;
   logic [PW-1:0]        g_idx;
   logic                 g_any;

   assign arb_req = req_valid & {NUM_PORTS{~rst}};

   lock_rr_arbiter #(
      .N           (NUM_PORTS),
      .ROUND_ROBIN (ARB_ROUND_ROBIN)
   ) u_arb (
      .clk     (clk),
      .rst     (rst),
      .req     (arb_req),
      .gnt     (req_gnt),
      .gnt_idx (g_idx),
      .gnt_any (g_any)
   );

   // selected request
   logic             sel_op;
   logic [ID_W-1:0]  sel_id;
   logic [VAL_W-1:0] sel_val;

   assign sel_op  = req_op[g_idx];
   assign sel_id  = req_id[g_idx*ID_W +: ID_W];
   assign sel_val = req_val[g_idx*VAL_W +: VAL_W];

   // table storage and associative search
   logic [NUM_ENTRIES-1:0]       ent_valid;
   logic [NUM_ENTRIES*ID_W-1:0]  ent_key;
   logic [NUM_ENTRIES*PW-1:0]    ent_own;
   logic [NUM_ENTRIES*VAL_W-1:0] ent_val;
   logic                         hit_any, free_any;
   logic [EW-1:0]                hit_idx, free_idx;
   logic                         alloc_en, clear_en;

   lock_entry_match #(
      .ENTRIES (NUM_ENTRIES),
      .KEY_W   (ID_W)
   ) u_match (
      .ent_valid (ent_valid),
      .ent_key   (ent_key),
      .key       (sel_id),
      .hit_any   (hit_any),
      .hit_idx   (hit_idx),
      .free_any  (free_any),
      .free_idx  (free_idx)
   );

   lock_entry_store #(
      .ENTRIES (NUM_ENTRIES),
      .KEY_W   (ID_W),
      .OWN_W   (PW),
      .VAL_W   (VAL_W)
   ) u_store (
      .clk       (clk),
      .rst       (rst),
      .alloc_en  (alloc_en),
      .alloc_idx (free_idx),
      .alloc_key (sel_id),
      .alloc_own (g_idx),
      .alloc_val (sel_val),
      .clear_en  (clear_en),
      .clear_idx (hit_idx),
      .ent_valid (ent_valid),
      .ent_key   (ent_key),
      .ent_own   (ent_own),
      .ent_val   (ent_val)
   );

   // decision for the granted request
   logic [PW-1:0]    hit_own;
   logic [VAL_W-1:0] hit_val;
   logic             owner_ok;
   logic             in_range;
   lock_res_e        res;
   logic [VAL_W-1:0] res_data;

   assign hit_own  = ent_own[hit_idx*PW +: PW];
   assign hit_val  = ent_val[hit_idx*VAL_W +: VAL_W];
   assign owner_ok = hit_any && (hit_own == g_idx);
   assign in_range = (sel_id >= lo_q) && (sel_id <= hi_q);

   always_comb begin
      alloc_en = 1'b0;
      clear_en = 1'b0;
      res      = RES_OK;
      res_data = '0;
      if (g_any && in_range) begin
         if (sel_op == OP_RELEASE) begin
            if (owner_ok) begin
               clear_en = 1'b1;
               res_data = hit_val;
            end else begin
               res = RES_NOT_OWNER;
            end
         end else if (hit_any) begin
            if (owner_ok) begin
               res_data = hit_val;
            end else begin
               res = RES_BUSY;
            end
         end else if (free_any) begin
            alloc_en = 1'b1;
         end else begin
            res = RES_FULL;
         end
      end
   end

   // response and trap registers
   always_ff @(posedge clk) begin
      if (rst) begin
         rsp_valid  <= '0;
         rsp_code   <= RES_OK;
         rsp_data   <= '0;
         trap_valid <= 1'b0;
         trap_port  <= '0;
      end else begin
         rsp_valid  <= (g_any && in_range) ? req_gnt : '0;
         rsp_code   <= res;
         rsp_data   <= res_data;
         trap_valid <= g_any && !in_range;
         trap_port  <= g_idx;
      end
   end

endmodule

// File: rtl/lock_table_chk.sv
module lock_table_chk #(
   parameter int NUM_PORTS = 4
) (
   input logic                 clk,
   input logic                 rst,
   input logic [NUM_PORTS-1:0] req_valid,
   input logic [NUM_PORTS-1:0] req_op,
   input logic [NUM_PORTS-1:0] req_gnt,
   input logic [NUM_PORTS-1:0] rsp_valid,
   input logic [1:0]           rsp_code,
   input logic                 trap_valid
);

   // R2
   one_grant_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(req_gnt));

   // R2
   grant_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
      ((req_gnt & ~req_valid) == '0));

   // R3
   rsp_follows_grant_chk: assert property (@(posedge clk) disable iff (rst)
      (|rsp_valid) |-> (rsp_valid == $past(req_gnt)));

   // R10
   trap_alone_chk: assert property (@(posedge clk) disable iff (rst)
      trap_valid |-> ((rsp_valid == '0) && $past(|req_gnt)));

   // R5 R7
   acquire_codes_chk: assert property (@(posedge clk) disable iff (rst)
      ((|rsp_valid) && (rsp_code == 2'd1 || rsp_code == 2'd2))
         |-> $past((req_gnt & ~req_op) != '0));

   // R9
   release_code_chk: assert property (@(posedge clk) disable iff (rst)
      ((|rsp_valid) && (rsp_code == 2'd3)) |-> $past((req_gnt & req_op) != '0));

endmodule

bind lock_table_unit lock_table_chk #(
   .NUM_PORTS (NUM_PORTS)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .req_valid  (req_valid),
   .req_op     (req_op),
   .req_gnt    (req_gnt),
   .rsp_valid  (rsp_valid),
   .rsp_code   (rsp_code),
   .trap_valid (trap_valid)
);

// File: tb/sim_lock_table_unit.sv
module sim_lock_table_unit;

   localparam int P  = 4;
   localparam int E  = 8;
   localparam int IW = 16;
   localparam int VW = 32;
   localparam int LO = 16'h0010;
   localparam int HI = 16'h0FFF;

   logic            clk = 1'b0;
   logic            rst;
   logic [IW-1:0]   cfg_id_lo, cfg_id_hi;
   logic [P-1:0]    req_valid, req_op;
   logic [P*IW-1:0] req_id;
   logic [P*VW-1:0] req_val;
   logic [P-1:0]    req_gnt, rsp_valid;
   logic [1:0]      rsp_code;
   logic [VW-1:0]   rsp_data;
   logic            trap_valid;
   logic [1:0]      trap_port;

   always #4 clk = ~clk;

   lock_table_unit #(
      .NUM_PORTS   (P),
      .NUM_ENTRIES (E),
      .ID_W        (IW),
      .VAL_W       (VW)
   ) u0 (
      .clk        (clk),
      .rst        (rst),
      .cfg_id_lo  (cfg_id_lo),
      .cfg_id_hi  (cfg_id_hi),
      .req_valid  (req_valid),
      .req_op     (req_op),
      .req_id     (req_id),
      .req_val    (req_val),
      .req_gnt    (req_gnt),
      .rsp_valid  (rsp_valid),
      .rsp_code   (rsp_code),
      .rsp_data   (rsp_data),
      .trap_valid (trap_valid),
      .trap_port  (trap_port)
   );

   typedef struct packed {
      logic          op;
      logic [IW-1:0] id;
      logic [VW-1:0] val;
   } rq_t;

   rq_t pq[P][$];

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // reference model state
   bit            mv[E];
   int            mid[E];
   int            mown[E];
   logic [VW-1:0] mval[E];
   int            ptr = 0;

   task automatic chk(string tag, string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic push(int p, bit op, int id, logic [VW-1:0] v);
      rq_t r;
      r.op  = op;
      r.id  = IW'(id);
      r.val = v;
      pq[p].push_back(r);
   endtask

   task automatic drive();
      for (int p = 0; p < P; p++) begin
         if (pq[p].size() > 0) begin
            req_valid[p]          = 1'b1;
            req_op[p]             = pq[p][0].op;
            req_id[p*IW +: IW]    = pq[p][0].id;
            req_val[p*VW +: VW]   = pq[p][0].val;
         end else begin
            req_valid[p]          = 1'b0;
            req_op[p]             = 1'b0;
            req_id[p*IW +: IW]    = '0;
            req_val[p*VW +: VW]   = '0;
         end
      end
   endtask

   task automatic step();
      int            g, h, f, ec;
      bit            ev, et;
      logic [VW-1:0] ed;
      string         tag;
      rq_t           r;
      drive();
      #1;
      g = -1;
      for (int k = 0; k < P; k++) begin
         if (g < 0 && pq[(ptr + k) % P].size() > 0) g = (ptr + k) % P;
      end
      chk("R2", "req_gnt", req_gnt, (g >= 0) ? (1 << g) : 0);
      ev = 0; et = 0; ec = 0; ed = '0; tag = "R3";
      if (g >= 0) begin
         r   = pq[g].pop_front();
         ptr = (g + 1) % P;
         if (int'(r.id) < LO || int'(r.id) > HI) begin
            et  = 1;
            tag = "R10";
         end else begin
            ev = 1;
            h  = -1;
            for (int e = 0; e < E; e++) if (mv[e] && mid[e] == int'(r.id)) h = e;
            if (r.op == 1'b0) begin
               if (h >= 0 && mown[h] == g) begin
                  ec = 0; ed = mval[h]; tag = "R6";
               end else if (h >= 0) begin
                  ec = 1; tag = "R5";
               end else begin
                  f = -1;
                  for (int e = E - 1; e >= 0; e--) if (!mv[e]) f = e;
                  if (f >= 0) begin
                     mv[f] = 1; mid[f] = int'(r.id); mown[f] = g; mval[f] = r.val;
                     ec = 0; tag = "R4";
                  end else begin
                     ec = 2; tag = "R7";
                  end
               end
            end else begin
               if (h >= 0 && mown[h] == g) begin
                  ec = 0; ed = mval[h]; mv[h] = 0; tag = "R8";
               end else begin
                  ec = 3; tag = "R9";
               end
            end
         end
      end
      @(posedge clk);
      #1;
      chk(tag, "rsp_valid", rsp_valid, ev ? (1 << g) : 0);
      if (ev) begin
         chk(tag, "rsp_code", rsp_code, ec);
         chk(tag, "rsp_data", rsp_data, ed);
      end
      chk(tag, "trap_valid", trap_valid, et);
      if (et) chk(tag, "trap_port", trap_port, g);
   endtask

   task automatic run();
      bit busy;
      busy = 1;
      while (busy) begin
         busy = 0;
         for (int p = 0; p < P; p++) if (pq[p].size() > 0) busy = 1;
         if (busy) step();
      end
      step();
   endtask

   initial begin : watchdog
      #(200000 * 8);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin : main
      int s;
      for (int e = 0; e < E; e++) begin
         mv[e] = 0; mid[e] = 0; mown[e] = 0; mval[e] = '0;
      end
      rst       = 1'b1;
      cfg_id_lo = 16'(LO);
      cfg_id_hi = 16'(HI);
      req_valid = '1;
      req_op    = '0;
      req_val   = {P{32'hDEAD0000}};
      req_id    = {P{16'h0020}};
      repeat (3) @(posedge clk);
      #1;
      // R1: requests held during reset are not granted and produce nothing
      chk("R1", "req_gnt in reset", req_gnt, 0);
      chk("R1", "rsp_valid in reset", rsp_valid, 0);
      chk("R1", "trap_valid in reset", trap_valid, 0);
      req_valid = '0;
      rst       = 1'b0;
      // R10: window changes after reset must be ignored
      cfg_id_lo = '0;
      cfg_id_hi = '1;

      // single-lock ownership sequence
      push(0, 0, 16'h0020, 32'hA1A1_0001); run();   // R4
      push(1, 0, 16'h0020, 32'hB2B2_0002); run();   // R5
      push(0, 0, 16'h0020, 32'hC3C3_0003); run();   // R6
      push(2, 1, 16'h0020, 32'h0);         run();   // R9
      push(0, 1, 16'h0020, 32'h0);         run();   // R8
      push(0, 1, 16'h0020, 32'h0);         run();   // R9

      // fill all entries from all ports at once, then full and owner cases
      for (int p = 0; p < P; p++) begin
         push(p, 0, 16'h0100 + p, 32'h1000 + p);
         push(p, 0, 16'h0104 + p, 32'h2000 + p);
      end
      run();
      push(3, 0, 16'h0200, 32'h3000); run();        // R7
      push(1, 0, 16'h0101, 32'h0);    run();        // R6 while full
      push(3, 1, 16'h0102, 32'h0);    run();        // R9 wrong owner
      push(2, 1, 16'h0102, 32'h0);    run();        // R8 frees a slot
      push(3, 0, 16'h0200, 32'h3001); run();        // R4 reuses the slot
      for (int p = 0; p < P; p++) begin
         push(p, 1, 16'h0100 + p, 32'h0);
         push(p, 1, 16'h0104 + p, 32'h0);
      end
      push(3, 1, 16'h0200, 32'h0);
      run();

      // window edges and traps, mixed with legal traffic
      push(1, 0, 16'h000F, 32'h4); run();           // R10 below window
      push(2, 0, 16'h1000, 32'h5); run();           // R10 above window
      push(0, 0, 16'h0010, 32'h6); run();           // lowest legal id
      push(3, 0, 16'h0FFF, 32'h7); run();           // highest legal id
      push(0, 1, 16'hFFFF, 32'h0);
      push(1, 1, 16'h0010, 32'h0);
      push(2, 0, 16'h0000, 32'h8);
      push(3, 1, 16'h0FFF, 32'h0);
      run();
      push(0, 1, 16'h0010, 32'h0); run();

      // four-way contention on one identifier
      for (int p = 0; p < P; p++) push(p, 0, 16'h0300, 32'h5000 + p);
      run();
      for (int p = 0; p < P; p++) push(p, 1, 16'h0300, 32'h0);
      run();

      // pseudo-random stream over a set larger than the table
      s = 32'h1234_5678;
      for (int n = 0; n < 160; n++) begin
         s = s * 1103515245 + 12345;
         push((s >>> 8) & 3, (s >>> 11) & 1, 16'h000C + ((s >>> 13) & 32'h7FFF) % 12,
              32'(s));
      end
      run();

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule